// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of 8-byte transmit descriptors held in an external memory. It reaches that memory through a simple request/acknowledge port. Each descriptor has two 32-bit words. The head word carries an ownership flag in bit 31, start and end-of-packet marks in bits 25:24, and a 24-bit buffer address in bits 23:0. The second word carries the byte count in bits 15:0, written as a negative two's-complement number, and a status half-word in bits 31:16.

When the walker finds a descriptor that hardware owns, it hands the buffer address and the positive byte count to a data mover. It then waits for the mover to report the outcome, writes the status back and hands ownership back to the host. Ring size and ring base come from one 32-bit pointer: bits 31:29 give log2 of the entry count and bits 23:0 give the base byte address.

A walk starts on a one-cycle demand pulse or when an idle poll timer expires. The walk goes on from descriptor to descriptor until it meets one that the host still owns. A FIFO underflow halts the transmitter until the host issues a restart.

Top module: `txring_walker`

## Requirements
- R1: After reset the walker issues no memory request, no mover start and no completion event, and its ring index is 0.
- R2: A `tx_demand` pulse while idle starts a walk. The walk reads the head word at `base + 8*index`, and the memory address and request stay stable until `mem_ack`.
- R3: If bit 31 of a head word read is 0, the walk ends. No mover start is issued and the descriptor is left unchanged.
- R4: For an owned descriptor, `mv_start` pulses for one cycle. At that pulse `mv_addr` equals head bits 23:0 and `mv_len` equals the two's-complement negation of bits 15:0 of the second word.
- R5: With `PAD_SHORT` = 1, a byte count below 60 is presented to the mover as 60. A byte count of 60 or more passes unchanged.
- R6: On completion the second word is written as {status, original length field}. In the status half-word, bit 10 is retry abort, bit 11 is loss of carrier, bit 12 is late collision and bit 14 is underflow. The head word is then written with bit 31 cleared and bits 25:0 kept. Bit 30 is set if any of the four errors occurred, bit 28 is set for multiple collisions and bit 27 for a single collision.
- R7: Descriptors are handled strictly in ring order. The index advances by one per completed descriptor and wraps from the last entry to entry 0. No access falls outside `base .. base + 8*size - 1`.
- R8: The ring size is 2^(ring_ptr[31:29]). A descriptor beyond the ring, even if owned, is never touched.
- R9: `tx_done` is high for exactly one cycle for each completed descriptor.
- R10: An underflow outcome completes its descriptor and then halts the walker. While halted, neither demand nor timer starts a walk. A `restart` pulse while idle clears the halt and sets the index to 0.
- R11: With no demand, an idle and non-halted walker starts a walk after `POLL_CYCLES` idle cycles.
- R12: After a completion the walker reads the next descriptor at once, without a new demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_ptr | input | 32 | [31:29] log2 of entry count, [23:0] ring base byte address |
| tx_demand | input | 1 | One-cycle request for an immediate poll |
| restart | input | 1 | Clears an underflow halt and rewinds the index (idle only) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle access acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mv_start | output | 1 | One-cycle start to the data mover |
| mv_addr | output | 24 | Buffer address for the mover |
| mv_len | output | 16 | Positive byte count for the mover |
| mv_done | input | 1 | One-cycle mover completion |
| mv_retry_abort | input | 1 | Outcome: retries exhausted |
| mv_no_carrier | input | 1 | Outcome: carrier lost |
| mv_late_coll | input | 1 | Outcome: late collision |
| mv_underflow | input | 1 | Outcome: FIFO underflow |
| mv_one_coll | input | 1 | Outcome: exactly one collision |
| mv_multi_coll | input | 1 | Outcome: more than one collision |
| tx_done | output | 1 | One-cycle event per completed descriptor |

## Verification
The checker watches several properties on every cycle:
- the memory request holds its address until it is acknowledged;
- `mv_start` and `tx_done` are single-cycle pulses;
- a head write-back never carries the ownership bit;
- no access leaves the ring window;
- a halted walker stays silent on both the memory and the mover ports.

Some behaviour only the directed scenarios can show: the exact status and head encodings written back, the padding of short frames, the wrap order across a ring boundary, the change in ring size, the effect of restart, and the spacing of timer polls.

// File: rtl/txw_pkg.sv
package txw_pkg;

  localparam int unsigned IDX_W     = 7;   // ring_ptr[31:29] allows up to 128 entries
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned MIN_FRAME = 60;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_HEAD, S_RD_LEN, S_MOVE, S_WR_LEN, S_WR_HEAD
  } walk_state_t;

  typedef struct packed {
    logic retry_abort;
    logic no_carrier;
    logic late_coll;
    logic underflow;
    logic one_coll;
    logic multi_coll;
  } tx_outcome_t;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [15:0] byte_count(input logic [15:0] neg_len);
    return 16'd0 - neg_len;
  endfunction

  function automatic logic [15:0] pad_count(input logic [15:0] cnt, input logic en);
    return (en && cnt < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : cnt;
  endfunction

  function automatic logic [15:0] status_half(input tx_outcome_t o);
    logic [15:0] s;
    s     = '0;
    s[10] = o.retry_abort;
    s[11] = o.no_carrier;
    s[12] = o.late_coll;
    s[14] = o.underflow;
    return s;
  endfunction

  function automatic logic [31:0] head_done(input logic [31:0] old, input tx_outcome_t o);
    logic [31:0] r;
    r     = old;
    r[31] = 1'b0;
    r[30] = o.retry_abort | o.no_carrier | o.late_coll | o.underflow;
    r[28] = o.multi_coll;
    r[27] = o.one_coll;
    return r;
  endfunction

endpackage

// File: rtl/txw_poll_timer.sv
module txw_poll_timer #(
  parameter int unsigned CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fire
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign fire = run && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || fire) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txw_ring_index.sv
module txw_ring_index #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [2:0]       log2_size,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] mask;

  assign mask = ~({IDX_W{1'b1}} << log2_size);
  assign idx  = idx_q & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (clr)  idx_q <= '0;
    else if (step) idx_q <= (idx + 1'b1) & mask;
  end
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txw_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 256,
  parameter bit          PAD_SHORT   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_ptr,
  input  logic        tx_demand,
  input  logic        restart,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        mv_start,
  output logic [23:0] mv_addr,
  output logic [15:0] mv_len,
  input  logic        mv_done,
  input  logic        mv_retry_abort,
  input  logic        mv_no_carrier,
  input  logic        mv_late_coll,
  input  logic        mv_underflow,
  input  logic        mv_one_coll,
  input  logic        mv_multi_coll,
  output logic        tx_done
);
  walk_state_t      state_q;
  logic [31:0]      head_q;
  logic [31:0]      len_q;
  tx_outcome_t      out_q;
  logic             halted;
  logic             start_q;
  logic             done_q;
  logic [IDX_W-1:0] idx;
  logic             timer_fire;
  logic             idle_run;
  logic             poll_go;
  logic             do_restart;
  logic             step_idx;
  logic             wr_head;
  logic [ADDR_W-1:0] slot;

  // Named internal events, also used by the checker
  assign idle_run   = (state_q == S_IDLE) && !halted;
  assign poll_go    = idle_run && (tx_demand || timer_fire);
  assign do_restart = (state_q == S_IDLE) && restart;
  assign wr_head    = (state_q == S_WR_HEAD);
  assign step_idx   = wr_head && mem_ack;

  txw_poll_timer #(.CYCLES(POLL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(idle_run), .fire(timer_fire)
  );

  txw_ring_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst_n(rst_n), .clr(do_restart), .step(step_idx),
    .log2_size(ring_ptr[31:29]), .idx(idx)
  );

  assign slot = slot_addr(ring_ptr[23:0], idx);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = slot;
    mem_wdata = '0;
    unique case (state_q)
      S_RD_HEAD: mem_req = 1'b1;
      S_RD_LEN:  begin mem_req = 1'b1; mem_addr = slot + 24'd4; end
      S_WR_LEN:  begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = slot + 24'd4;
        mem_wdata = {status_half(out_q), len_q[15:0]};
      end
      S_WR_HEAD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = head_done(head_q, out_q);
      end
      default: ;
    endcase
  end

  assign mv_start = start_q;
  assign mv_addr  = head_q[23:0];
  assign mv_len   = pad_count(byte_count(len_q[15:0]), PAD_SHORT);
  assign tx_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      head_q  <= '0;
      len_q   <= '0;
      out_q   <= '0;
      halted  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (do_restart)   halted  <= 1'b0;
          else if (poll_go) state_q <= S_RD_HEAD;
        end
        S_RD_HEAD: if (mem_ack) begin
          head_q  <= mem_rdata;
          state_q <= mem_rdata[31] ? S_RD_LEN : S_IDLE;
        end
        S_RD_LEN: if (mem_ack) begin
          len_q   <= mem_rdata;
          start_q <= 1'b1;
          state_q <= S_MOVE;
        end
        S_MOVE: if (mv_done) begin
          out_q   <= '{retry_abort: mv_retry_abort, no_carrier: mv_no_carrier,
                       late_coll: mv_late_coll, underflow: mv_underflow,
                       one_coll: mv_one_coll, multi_coll: mv_multi_coll};
          state_q <= S_WR_LEN;
        end
        S_WR_LEN: if (mem_ack) state_q <= S_WR_HEAD;
        S_WR_HEAD: if (mem_ack) begin
          done_q <= 1'b1;
          if (out_q.underflow) begin
            halted  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD_HEAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txw_chk.sv
module txw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ring_ptr,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [23:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mv_start,
  input logic        tx_done,
  input logic        halted,
  input logic        wr_head
);
  logic [24:0] offset;
  logic [24:0] window;
  assign offset = {1'b0, mem_addr} - {1'b0, ring_ptr[23:0]};
  assign window = 25'd8 << ring_ptr[31:29];

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && wr_head |-> !mem_wdata[31]);

  // R7
  in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> offset < window);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req && !mv_start);
endmodule

bind txring_walker txw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ring_ptr(ring_ptr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mv_start(mv_start), .tx_done(tx_done),
  .halted(halted), .wr_head(wr_head)
);

// File: tb/sim_txring_walker.sv
module sim_txring_walker;
  localparam int POLL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_ptr = {3'd2, 5'd0, 24'h000040};
  logic        tx_demand = 1'b0, restart = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        mv_start, mv_done = 1'b0;
  logic [23:0] mv_addr;
  logic [15:0] mv_len;
  logic        tx_done;
  logic [5:0]  stub_out = '0; // retry, carrier, late, underflow, one, multi

  always #5 clk = ~clk;

  txring_walker #(.POLL_CYCLES(POLL), .PAD_SHORT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_ptr(ring_ptr), .tx_demand(tx_demand),
    .restart(restart), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
    .mv_retry_abort(stub_out[5]), .mv_no_carrier(stub_out[4]),
    .mv_late_coll(stub_out[3]), .mv_underflow(stub_out[2]),
    .mv_one_coll(stub_out[1]), .mv_multi_coll(stub_out[0]), .tx_done(tx_done)
  );

  logic [31:0] mem [64];
  int cyc = 0, head_reads = 0, starts = 0, dones = 0, mv_cnt = 0;
  logic [23:0] last_rd_addr = '0;
  logic [23:0] mv_log [64];
  logic [15:0] len_log [64];
  int rd_cyc [256];
  int total = 0, bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: one-cycle registered acknowledge
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[7:2]];
        if (!mem_addr[2]) begin
          head_reads   <= head_reads + 1;
          last_rd_addr <= mem_addr;
          if (head_reads < 256) rd_cyc[head_reads] <= cyc;
        end
      end
    end
  end

  // data mover stub
  always @(posedge clk) begin
    mv_done <= 1'b0;
    if (mv_start) begin
      mv_cnt <= 3;
      if (starts < 64) begin mv_log[starts] <= mv_addr; len_log[starts] <= mv_len; end
      starts <= starts + 1;
    end else if (mv_cnt != 0) begin
      mv_cnt <= mv_cnt - 1;
      if (mv_cnt == 1) mv_done <= 1'b1;
    end
    if (tx_done) dones <= dones + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_demand();
    @(negedge clk) tx_demand = 1'b1;
    @(negedge clk) tx_demand = 1'b0;
  endtask

  task automatic wait_dones(input int n, input string req);
    int t;
    t = 0;
    while (dones < n && t < 1000) begin @(negedge clk); t++; end
    check(dones >= n, req, dones, n);
  endtask

  task automatic t_reset();
    cycles(3);
    check(!mem_req && !mv_start && !tx_done, "R1", {mem_req, mv_start, tx_done}, 0);
    rst_n = 1'b1;
    cycles(2);
    check(!mem_req && !mv_start, "R1", {mem_req, mv_start}, 0);
  endtask

  task automatic t_not_owned();
    pulse_demand();
    cycles(8);
    check(last_rd_addr == 24'h40, "R2", last_rd_addr, 24'h40);
    check(starts == 0, "R3", starts, 0);
    check(mem[16] == 32'h0 && mem[17] == 32'h0, "R3", mem[16], 0);
  endtask

  task automatic t_single();
    mem[16] = 32'h8300_1234; mem[17] = 32'h0000_FF9C; stub_out = '0;
    pulse_demand();
    wait_dones(1, "R9");
    cycles(6);
    check(mv_log[0] == 24'h001234, "R4", mv_log[0], 24'h001234);
    check(len_log[0] == 16'd100, "R4", len_log[0], 100);
    check(mem[16] == 32'h0300_1234, "R6", mem[16], 32'h0300_1234);
    check(mem[17] == 32'h0000_FF9C, "R6", mem[17], 32'h0000_FF9C);
    check(last_rd_addr == 24'h48 && dones == 1, "R12", last_rd_addr, 24'h48);
  endtask

  task automatic t_pad();
    mem[18] = 32'h8300_0200; mem[19] = 32'h0000_FFEC; stub_out = 6'b000010;
    pulse_demand();
    wait_dones(2, "R9");
    cycles(6);
    check(len_log[1] == 16'd60, "R5", len_log[1], 60);
    check(mem[18] == 32'h0B00_0200, "R6", mem[18], 32'h0B00_0200);
    check(mem[19] == 32'h0000_FFEC, "R6", mem[19], 32'h0000_FFEC);
  endtask

  task automatic t_errors();
    mem[20] = 32'h8300_0300; mem[21] = 32'h0000_FF38; stub_out = 6'b111001;
    pulse_demand();
    wait_dones(3, "R9");
    cycles(6);
    check(len_log[2] == 16'd200, "R5", len_log[2], 200);
    check(mem[20] == 32'h5300_0300, "R6", mem[20], 32'h5300_0300);
    check(mem[21] == 32'h1C00_FF38, "R6", mem[21], 32'h1C00_FF38);
  endtask

  task automatic t_wrap();
    mem[22] = 32'h8300_0400; mem[23] = 32'h0000_FFC4;
    mem[16] = 32'h8300_0500; mem[17] = 32'h0000_FFC0; stub_out = '0;
    pulse_demand();
    wait_dones(5, "R12");
    cycles(6);
    check(mv_log[3] == 24'h000400, "R7", mv_log[3], 24'h400);
    check(mv_log[4] == 24'h000500, "R7", mv_log[4], 24'h500);
    check(len_log[3] == 16'd60, "R5", len_log[3], 60);
    check(mem[16] == 32'h0300_0500, "R7", mem[16], 32'h0300_0500);
    check(last_rd_addr == 24'h48, "R7", last_rd_addr, 24'h48);
  endtask

  task automatic t_underflow();
    int s0;
    mem[18] = 32'h8300_0600; mem[19] = 32'h0000_FFC0;
    mem[20] = 32'h8300_0700; mem[21] = 32'h0000_FFC0; stub_out = 6'b000100;
    pulse_demand();
    wait_dones(6, "R10");
    cycles(4);
    s0 = starts;
    check(mem[18] == 32'h4300_0600, "R10", mem[18], 32'h4300_0600);
    check(mem[19] == 32'h4000_FFC0, "R6", mem[19], 32'h4000_FFC0);
    cycles(POLL * 2);
    pulse_demand();
    cycles(10);
    check(mem[20] == 32'h8300_0700, "R10", mem[20], 32'h8300_0700);
    check(starts == s0, "R10", starts, s0);
  endtask

  task automatic t_restart_size();
    stub_out = '0;
    ring_ptr = {3'd1, 5'd0, 24'h000040};
    mem[16] = 32'h8300_0800; mem[17] = 32'h0000_FFC0;
    mem[18] = 32'h8300_0900; mem[19] = 32'h0000_FFC0;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    pulse_demand();
    wait_dones(8, "R10");
    cycles(6);
    check(mv_log[6] == 24'h000800 && mv_log[7] == 24'h000900, "R10", mv_log[6], 24'h800);
    check(mem[20] == 32'h8300_0700, "R8", mem[20], 32'h8300_0700);
    check(last_rd_addr == 24'h40, "R8", last_rd_addr, 24'h40);
  endtask

  task automatic t_timer();
    int n0, t, gap;
    n0 = head_reads;
    mem[16] = 32'h8300_0A00; mem[17] = 32'h0000_FFC0;
    t = 0;
    while (dones < 9 && t < POLL + 40) begin @(negedge clk); t++; end
    check(dones == 9, "R11", dones, 9);
    gap = (n0 > 0 && n0 < 256) ? rd_cyc[n0] - rd_cyc[n0-1] : 0;
    check(gap >= POLL && gap <= POLL + 8, "R11", gap, POLL);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    t_reset();
    t_not_owned();
    t_single();
    t_pad();
    t_errors();
    t_wrap();
    t_underflow();
    t_restart_size();
    t_timer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule